// File: doc/BRIEF.md
# BCH Syndrome Expansion Unit

This unit sits in the read path of a binary BCH decoder over GF(2^13). A remainder stage upstream leaves one 13-bit partial value for each odd syndrome index. The values come packed two to a 32-bit word. On a start request this unit turns them into the full set of syndromes S1..S2t that the key-equation solver downstream needs. The correction capability t is 2, 4, 8, 12 or 24.

Each odd syndrome S_i is the GF sum of alpha^(i*j) taken over the set bits j of its partial value. The unit builds these one bit per cycle from a running power. Each even syndrome S_i is the square of S_(i/2). All arithmetic is combinational GF logic over the primitive polynomial x^13 + x^4 + x^3 + x + 1. There are no lookup tables. Once the last syndrome is written, a single-cycle completion pulse is raised. The results can then be read through an indexed read port.

Top module: `bch_syn_expand`

## Requirements
- R1: While reset is high and after it, busy and done are low, and every syndrome slot reads as zero.
- R2: The capability code is sampled on an accepted start. Codes 0, 1, 2, 3 and 4 give t = 2, 4, 8, 12 and 24; codes 5 to 7 give t = 2. Only slots 1..2t are written during the run.
- R3: The partial value for odd index 2k+1 (k = 0..t-1) comes from packed word k/2: bits 12:0 when k is even and bits 28:16 when k is odd. Bits 15:13 and 31:29 of each word have no effect.
- R4: For odd i, S_i is the XOR of alpha^(i*j) over the set bits j (0..12) of its partial value. Alpha is the root 0x0002 of x^13+x^4+x^3+x+1, and field elements are 13-bit polynomial-basis vectors.
- R5: For even i, S_i equals S_(i/2) squared in the same field, which is zero when S_(i/2) is zero.
- R6: An accepted start clears every slot. Slots above 2t read zero after a run, even if an earlier run with a larger t wrote them.
- R7: Take the clock edge that accepts start as edge 0. After edges 0 to 15t-1, busy is high and done is low. After edge 15t, done is high for exactly one cycle and busy is low.
- R8: A start request while busy is ignored. Timing, capability and results stay those of the run in progress.
- R9: The read port returns slot n for index n in 1..48 in the same cycle. Index 0 and indices above 48 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted only when idle |
| cap_code_i | input | 3 | Correction capability code |
| psyn_words_i | input | 384 | Twelve packed words of two partial values each, word w at bits 32w+31:32w; held stable while busy |
| rd_idx_i | input | 6 | Syndrome read index |
| rd_syn_o | output | 13 | Syndrome value at the read index |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle pulse when the last syndrome is written |

## Verification
The assertions check the following on every cycle:
- the handshake: a single-cycle done that coincides with the fall of busy, busy rising after an accepted start, and a start while busy not cutting the run short;
- that writes stay inside slots 1..2t;
- that out-of-range reads return zero.

Only the bench scenarios can show that the syndrome values are correct. It compares them against an independent field model over several capabilities and partial patterns, including all-zero and single-bit partials. The bench scenarios also show the clearing of stale slots after a smaller-t run, the exact 15t-cycle latency, and that the don't-care bits of the packed words have no effect.

// File: rtl/bch_syn_pkg.sv
package bch_syn_pkg;

    localparam int GF_M      = 13;
    localparam int MAX_T     = 24;
    localparam int NUM_SYN   = 2 * MAX_T;
    localparam int WORD_W    = 32;
    localparam int HALF_W    = WORD_W / 2;
    localparam int NUM_WORDS = MAX_T / 2;
    localparam int IDX_W     = $clog2(NUM_SYN + 1);
    localparam int BIT_W     = $clog2(GF_M);

    // low terms of x^13 + x^4 + x^3 + x + 1
    localparam logic [GF_M-1:0] PRIM_LOW = 13'h001B;
    localparam logic [GF_M-1:0] ALPHA_1  = 13'h0002;
    localparam logic [GF_M-1:0] ALPHA_2  = 13'h0004;

    typedef logic [GF_M-1:0] gf_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ODD_LOAD,
        ST_ODD_RUN,
        ST_EVEN
    } syn_state_e;

    typedef struct packed {
        syn_state_e st;
        idx_t       k;      // odd partial counter 0..t-1
        idx_t       ev;     // even syndrome index
        idx_t       t;      // latched capability
        gf_t        ai;     // alpha^(2k+1)
        logic       done;
    } syn_ctl_t;

    function automatic gf_t gf_xtime(gf_t x);
        return {x[GF_M-2:0], 1'b0} ^ (x[GF_M-1] ? PRIM_LOW : '0);
    endfunction

    function automatic gf_t gf_mul(gf_t a, gf_t b);
        gf_t r;
        r = '0;
        for (int n = GF_M - 1; n >= 0; n--) begin
            r = gf_xtime(r) ^ (b[n] ? a : '0);
        end
        return r;
    endfunction

    function automatic gf_t gf_sq(gf_t a);
        return gf_mul(a, a);
    endfunction

    function automatic idx_t cap_decode(logic [2:0] code);
        case (code)
            3'd1:    return idx_t'(4);
            3'd2:    return idx_t'(8);
            3'd3:    return idx_t'(12);
            3'd4:    return idx_t'(24);
            default: return idx_t'(2);
        endcase
    endfunction

endpackage

// File: rtl/bch_odd_accum.sv
module bch_odd_accum
    import bch_syn_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic step_i,
    input  gf_t  base_i,
    input  gf_t  part_i,
    output gf_t  sum_o,
    output logic last_o
);
    gf_t              acc_q;
    gf_t              pw_q;
    gf_t              mult_q;
    gf_t              part_q;
    logic [BIT_W-1:0] bit_q;

    assign sum_o  = acc_q ^ (part_q[0] ? pw_q : '0);
    assign last_o = (bit_q == BIT_W'(GF_M - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            pw_q   <= '0;
            mult_q <= '0;
            part_q <= '0;
            bit_q  <= '0;
        end else if (load_i) begin
            acc_q  <= '0;
            pw_q   <= gf_t'(1);
            mult_q <= base_i;
            part_q <= part_i;
            bit_q  <= '0;
        end else if (step_i) begin
            acc_q  <= sum_o;
            pw_q   <= gf_mul(pw_q, mult_q);
            part_q <= part_q >> 1;
            bit_q  <= bit_q + 1'b1;
        end
    end
endmodule

// File: rtl/bch_syn_store.sv
module bch_syn_store
    import bch_syn_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic wr_en_i,
    input  idx_t wr_idx_i,
    input  gf_t  wr_data_i,
    input  idx_t sq_idx_i,
    output gf_t  sq_data_o,
    input  idx_t rd_idx_i,
    output gf_t  rd_data_o
);
    gf_t slot_q [1:NUM_SYN];

    for (genvar g = 1; g <= NUM_SYN; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clear_i) begin
                slot_q[g] <= '0;
            end else if (wr_en_i && wr_idx_i == idx_t'(g)) begin
                slot_q[g] <= wr_data_i;
            end
        end
    end

    always_comb begin
        sq_data_o = '0;
        rd_data_o = '0;
        if (sq_idx_i >= idx_t'(1) && sq_idx_i <= idx_t'(NUM_SYN)) begin
            sq_data_o = slot_q[sq_idx_i];
        end
        if (rd_idx_i >= idx_t'(1) && rd_idx_i <= idx_t'(NUM_SYN)) begin
            rd_data_o = slot_q[rd_idx_i];
        end
    end
endmodule

// File: rtl/bch_syn_expand.sv
module bch_syn_expand
    import bch_syn_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start_i,
    input  logic [2:0]                  cap_code_i,
    input  logic [NUM_WORDS*WORD_W-1:0] psyn_words_i,
    input  logic [IDX_W-1:0]            rd_idx_i,
    output logic [GF_M-1:0]             rd_syn_o,
    output logic                        busy_o,
    output logic                        done_o
);
    localparam int SEL_W = $clog2(NUM_WORDS * WORD_W);

    syn_ctl_t ctl_q, ctl_d;

    logic acc_load, acc_step, acc_last;
    gf_t  acc_sum;
    gf_t  part_sel;
    logic st_clear, st_wr_en;
    idx_t st_wr_idx;
    gf_t  st_wr_data;
    idx_t sq_idx;
    gf_t  sq_data;
    logic [SEL_W-1:0] part_base;

    // word k/2, low half for even k, high half for odd k
    assign part_base = SEL_W'((32'(ctl_q.k) >> 1) * WORD_W + (ctl_q.k[0] ? HALF_W : 0));
    assign part_sel  = psyn_words_i[part_base +: GF_M];
    assign sq_idx    = ctl_q.ev >> 1;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        acc_load   = 1'b0;
        acc_step   = 1'b0;
        st_clear   = 1'b0;
        st_wr_en   = 1'b0;
        st_wr_idx  = '0;
        st_wr_data = '0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    st_clear = 1'b1;
                    ctl_d.t  = cap_decode(cap_code_i);
                    ctl_d.k  = '0;
                    ctl_d.ai = ALPHA_1;
                    ctl_d.st = ST_ODD_LOAD;
                end
            end
            ST_ODD_LOAD: begin
                acc_load = 1'b1;
                ctl_d.st = ST_ODD_RUN;
            end
            ST_ODD_RUN: begin
                acc_step = 1'b1;
                if (acc_last) begin
                    st_wr_en   = 1'b1;
                    st_wr_idx  = idx_t'({ctl_q.k, 1'b1});
                    st_wr_data = acc_sum;
                    ctl_d.ai   = gf_mul(ctl_q.ai, ALPHA_2);
                    if (ctl_q.k == ctl_q.t - 1'b1) begin
                        ctl_d.ev = idx_t'(2);
                        ctl_d.st = ST_EVEN;
                    end else begin
                        ctl_d.k  = ctl_q.k + 1'b1;
                        ctl_d.st = ST_ODD_LOAD;
                    end
                end
            end
            ST_EVEN: begin
                st_wr_en   = 1'b1;
                st_wr_idx  = ctl_q.ev;
                st_wr_data = gf_sq(sq_data);
                if (ctl_q.ev == idx_t'({ctl_q.t, 1'b0})) begin
                    ctl_d.done = 1'b1;
                    ctl_d.st   = ST_IDLE;
                end else begin
                    ctl_d.ev = ctl_q.ev + idx_t'(2);
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    bch_odd_accum u_odd (
        .clk    (clk),
        .rst    (rst),
        .load_i (acc_load),
        .step_i (acc_step),
        .base_i (ctl_q.ai),
        .part_i (part_sel),
        .sum_o  (acc_sum),
        .last_o (acc_last)
    );

    bch_syn_store u_store (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (st_clear),
        .wr_en_i   (st_wr_en),
        .wr_idx_i  (st_wr_idx),
        .wr_data_i (st_wr_data),
        .sq_idx_i  (sq_idx),
        .sq_data_o (sq_data),
        .rd_idx_i  (rd_idx_i),
        .rd_data_o (rd_syn_o)
    );

    assign busy_o = (ctl_q.st != ST_IDLE);
    assign done_o = ctl_q.done;
endmodule

// File: rtl/bch_syn_expand_chk.sv
module bch_syn_expand_chk
    import bch_syn_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input idx_t rd_idx_i,
    input gf_t  rd_syn_o,
    input logic wr_en,
    input idx_t wr_idx,
    input idx_t t_val
);
    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!busy_o && !done_o)); // R1

    AST_WRITE_RANGE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_idx != '0 && int'(wr_idx) <= 2 * int'(t_val))); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7

    AST_DONE_CLOSES_BUSY: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o); // R7

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o); // R7

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (start_i && busy_o) |=> (busy_o || done_o)); // R8

    AST_READ_OUT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (rd_idx_i == '0 || int'(rd_idx_i) > NUM_SYN) |-> rd_syn_o == '0); // R9
endmodule

bind bch_syn_expand bch_syn_expand_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .rd_idx_i (rd_idx_i),
    .rd_syn_o (rd_syn_o),
    .wr_en    (st_wr_en),
    .wr_idx   (st_wr_idx),
    .t_val    (ctl_q.t)
);

// File: tb/test_bch_syn_expand.sv
`timescale 1ns/1ps
module test_bch_syn_expand;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [2:0]   cap_code_i = '0;
    logic [383:0] psyn_words_i = '0;
    logic [5:0]   rd_idx_i = '0;
    logic [12:0]  rd_syn_o;
    logic         busy_o, done_o;

    int checks = 0;
    int fails  = 0;
    int exp_syn [49];

    always #2.5 clk = ~clk;

    bch_syn_expand i_bch_syn_expand (
        .clk(clk), .rst(rst), .start_i(start_i), .cap_code_i(cap_code_i),
        .psyn_words_i(psyn_words_i), .rd_idx_i(rd_idx_i), .rd_syn_o(rd_syn_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // LSB-first multiply, reducing the multiplicand each step
    function automatic int rmul(int a, int b);
        int r = 0;
        int x = a;
        for (int n = 0; n < 13; n++) begin
            if (((b >> n) & 1) != 0) r ^= x;
            x = x << 1;
            if ((x & 'h2000) != 0) x ^= 'h201B;
        end
        return r;
    endfunction

    function automatic int apow(int e);
        int x = 1;
        for (int n = 0; n < e; n++) x = rmul(x, 2);
        return x;
    endfunction

    function automatic int tval(int code);
        case (code)
            1: return 4;
            2: return 8;
            3: return 12;
            4: return 24;
            default: return 2;
        endcase
    endfunction

    task automatic build_expected(int t);
        for (int n = 0; n < 49; n++) exp_syn[n] = 0;
        for (int k = 0; k < t; k++) begin
            int half;
            int i;
            half = int'(psyn_words_i[(k/2)*32 + (k%2)*16 +: 16]) & 'h1FFF;
            i = 2*k + 1;
            for (int j = 0; j < 13; j++)
                if (((half >> j) & 1) != 0) exp_syn[i] ^= apow(i*j);
        end
        for (int i = 2; i <= 2*t; i += 2)
            exp_syn[i] = rmul(exp_syn[i/2], exp_syn[i/2]);
    endtask

    task automatic read_all(string req);
        for (int n = 1; n <= 48; n++) begin
            rd_idx_i = 6'(n);
            #0.5;
            check(req, int'(rd_syn_o), exp_syn[n], $sformatf("slot %0d", n));
        end
        rd_idx_i = '0;
    endtask

    // cycle-by-cycle comparison of the handshake; optional stray start at cycle inj
    task automatic run(int code, int inj, int inj_code);
        int t;
        t = tval(code);
        build_expected(t);
        @(negedge clk);
        cap_code_i = 3'(code);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k <= 15*t + 1; k++) begin
            string req;
            req = (k > inj && inj >= 0 && k <= inj + 2) ? "R8" : "R7";
            check(req, int'(busy_o), (k < 15*t) ? 1 : 0, $sformatf("busy cycle %0d", k));
            check(req, int'(done_o), (k == 15*t) ? 1 : 0, $sformatf("done cycle %0d", k));
            if (k == inj) begin
                start_i = 1'b1;
                cap_code_i = 3'(inj_code);
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 5.0);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs and slots during reset
        check("R1", int'(busy_o), 0, "busy in reset");
        check("R1", int'(done_o), 0, "done in reset");
        rst = 1'b0;
        @(negedge clk);
        for (int n = 0; n < 49; n++) exp_syn[n] = 0;
        read_all("R1");

        // R3 R4 R5: t=24, random partials with don't-care bits set
        for (int w = 0; w < 12; w++) psyn_words_i[w*32 +: 32] = $urandom() | 32'hE000_E000;
        run(4, -1, 0);
        read_all("R4");

        // R6: smaller t clears stale upper slots
        for (int w = 0; w < 12; w++) psyn_words_i[w*32 +: 32] = $urandom();
        run(0, -1, 0);
        read_all("R6");

        // R5: single bit 0 partials give ones everywhere
        for (int w = 0; w < 12; w++) psyn_words_i[w*32 +: 32] = 32'h0001_0001;
        run(1, -1, 0);
        read_all("R5");

        // R5: all-zero partials yield zero squares
        psyn_words_i = '0;
        run(3, -1, 0);
        read_all("R5");

        // R8: stray start while busy with another code, t=8 run
        for (int w = 0; w < 12; w++) psyn_words_i[w*32 +: 32] = $urandom();
        run(2, 20, 4);
        read_all("R8");

        // R3: only the don't-care bits change, same results
        psyn_words_i = '0;
        for (int w = 0; w < 12; w++) psyn_words_i[w*32 +: 32] = 32'hE000_E000 | (32'(w) * 32'h0011_0013);
        run(1, -1, 0);
        read_all("R3");

        // R2: code 6 behaves as t=2
        run(6, -1, 0);
        read_all("R2");

        // R9: out-of-range read indices
        rd_idx_i = 6'd0;
        #0.5;
        check("R9", int'(rd_syn_o), 0, "index 0");
        rd_idx_i = 6'd63;
        #0.5;
        check("R9", int'(rd_syn_o), 0, "index 63");
        rd_idx_i = 6'd1;
        #0.5;
        check("R9", int'(rd_syn_o), exp_syn[1], "index 1");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule